// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a word-organised serial EEPROM with 128 words of 16 bits. A host drives a chip-select, a serial clock and a serial data input. The block answers on a serial data output that it can release to high impedance, given here as a data bit plus an output enable. All three host inputs are resynchronised into a fast system clock. Every command step is taken on a detected rising edge of the serial clock.

A command opens with a start bit. A 2-bit opcode follows, then an 8-bit field, and for the two store commands a 16-bit data word. The block supports word read with automatic address advance, word write, word erase, fill-all, clear-all, and setting or clearing a write-protect latch. A programming cycle runs for a parameterised number of system clocks. If chip-select is raised again during that cycle, the output shows whether the device is still busy or already ready.

Top module: `uwire_eeprom`

## Requirements
- R1: While chip-select is high, zeros on DI before the first one are ignored. The first DI=1 sampled on a serial-clock rise is the start bit.
- R2: The 2-bit opcode after the start bit is decoded as 10 = read, 01 = write, 11 = erase and 00 = special. For special, the first two bits of the 8-bit field pick the command: 11 enables writes, 00 disables writes, 01 fills all words, 10 clears all words. For word commands the field is a leading 0 followed by the 7-bit address, most significant bit first.
- R3: On read, DO is enabled and drives 0 for the serial-clock rise that takes the last address bit. It then drives the word's bits from bit 15 down to bit 0, one per rise.
- R4: If clocking continues during a read, the words at the following addresses are sent back to back. The address wraps from 127 to 0.
- R5: After reset, writes are disabled. Write, erase, fill-all and clear-all have no effect and start no programming cycle until writes are enabled, and they are ignored again once writes are disabled. Read works in both states.
- R6: A write stores its 16 data bits, most significant first, only when chip-select falls after the last data bit. If chip-select falls earlier, nothing is programmed.
- R7: Erase sets the addressed word to 16'hFFFF. Fill-all stores the shifted-in word in all 128 locations in one programming cycle. Clear-all sets every location to 16'hFFFF.
- R8: During a programming cycle, raising chip-select makes DO show 0 (busy) and then 1 (ready) once the cycle ends. No start bit is accepted while the device is busy.
- R9: DO is disabled whenever chip-select is low. Dropping chip-select abandons any command in progress.
- R10: After reset every word reads 16'hFFFF and DO is disabled.
- R11: Once ready is shown, a DI=1 sampled on a serial-clock rise with chip-select still high starts a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial command, address and data input |
| do_o | output | 1 | Serial data or busy/ready status |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
Three kinds of internal fault are visible at the pins, and each is targeted separately. A wrong decode or bit counter moves the dummy zero, or the first data bit of a read, by one serial clock. A read-back right after the command then shows the whole word shifted. A wrong write-protect or cancel decision shows up at once: chip-select is raised again and the busy indication is either present or missing. The stored words are then read back after each store. A fault in the busy timer or in the refusal of start bits while busy appears within one programming time, because a read issued during the cycle returns status instead of data.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
  localparam int OP_BITS = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_OPC, ST_FIELD, ST_DATA, ST_ARMED, ST_READ, ST_HOLD
  } uwe_state_e;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00, OP_WRITE = 2'b01, OP_READ = 2'b10, OP_ERASE = 2'b11
  } uwe_op_e;

  typedef enum logic [1:0] {
    SP_WDS = 2'b00, SP_WRAL = 2'b01, SP_ERAL = 2'b10, SP_WEN = 2'b11
  } uwe_spec_e;
endpackage

// File: rtl/uwe_sync.sv
module uwe_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] s_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= a_i[g];
        stab_q <= meta_q;
      end
    end
    assign s_o[g] = stab_q;
  end
endmodule

// File: rtl/uwe_timer.sv
module uwe_timer #(
  parameter int PROG_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)              cnt_d = TW'(PROG_CYCLES);
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uwe_array.sv
module uwe_array #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic          all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (all_i || (waddr_i == AW'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uwe_ctrl.sv
module uwe_ctrl
  import uwe_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sk_rise_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          prog_start_o,
  output logic          prog_all_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [DW-1:0] prog_data_o,
  output logic          wen_o,
  output logic          start_acc_o,
  output logic          do_o,
  output logic          do_oe_o
);
  localparam int FW = AW + 1;
  localparam int CW = $clog2(DW + FW);

  uwe_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    op_q, op_d;
  logic [FW-1:0] fld_q, fld_d, fld_nx;
  logic [DW-1:0] data_q, data_d, rd_sh;
  logic [AW-1:0] addr_q, addr_d;
  logic          wen_q, wen_d, stat_q, stat_d, all_q, all_d;
  logic          do_q, do_d, oe_q, oe_d;

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; op_d = op_q; fld_d = fld_q;
    data_d = data_q; addr_d = addr_q; wen_d = wen_q; stat_d = stat_q;
    all_d = all_q; do_d = do_q;
    start_acc_o = 1'b0;
    prog_start_o = 1'b0;
    fld_nx = {fld_q[FW-2:0], di_i};
    rd_sh = rd_data_i << cnt_q;
    if (!cs_i) begin
      state_d = ST_IDLE;
      cnt_d = '0;
      if (state_q == ST_ARMED) begin
        prog_start_o = 1'b1;
        stat_d = 1'b1;
      end
    end else if (state_q == ST_IDLE) begin
      state_d = ST_START;
    end else if (sk_rise_i) begin
      unique case (state_q)
        ST_START: if (di_i && !busy_i) begin
          state_d = ST_OPC; cnt_d = '0; stat_d = 1'b0; start_acc_o = 1'b1;
        end
        ST_OPC: begin
          op_d = {op_q[0], di_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(OP_BITS - 1)) begin state_d = ST_FIELD; cnt_d = '0; end
        end
        ST_FIELD: begin
          fld_d = fld_nx;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(FW - 1)) begin
            cnt_d = '0;
            state_d = ST_HOLD;
            all_d = 1'b0;
            unique case (op_q)
              OP_READ:  begin state_d = ST_READ; do_d = 1'b0; addr_d = fld_nx[AW-1:0]; end
              OP_WRITE: if (wen_q) state_d = ST_DATA;
              OP_ERASE: if (wen_q) begin state_d = ST_ARMED; data_d = '1; end
              default: unique case (fld_nx[FW-1 -: 2])
                SP_WEN:  wen_d = 1'b1;
                SP_WDS:  wen_d = 1'b0;
                SP_WRAL: if (wen_q) begin state_d = ST_DATA; all_d = 1'b1; end
                default: if (wen_q) begin state_d = ST_ARMED; data_d = '1; all_d = 1'b1; end
              endcase
            endcase
          end
        end
        ST_DATA: begin
          data_d = {data_q[DW-2:0], di_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) begin state_d = ST_ARMED; cnt_d = '0; end
        end
        ST_READ: begin
          do_d = rd_sh[DW-1];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) begin cnt_d = '0; addr_d = addr_q + 1'b1; end
        end
        default: ;
      endcase
    end
    if (state_d == ST_START && stat_d) do_d = !busy_i;
    oe_d = cs_i && ((state_d == ST_READ) || (state_d == ST_START && stat_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; op_q <= '0; fld_q <= '0;
      data_q <= '0; addr_q <= '0; wen_q <= 1'b0; stat_q <= 1'b0;
      all_q <= 1'b0; do_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; op_q <= op_d; fld_q <= fld_d;
      data_q <= data_d; addr_q <= addr_d; wen_q <= wen_d; stat_q <= stat_d;
      all_q <= all_d; do_q <= do_d; oe_q <= oe_d;
    end
  end

  assign rd_addr_o   = addr_q;
  assign prog_all_o  = all_q;
  assign prog_addr_o = fld_q[AW-1:0];
  assign prog_data_o = data_q;
  assign wen_o       = wen_q;
  assign do_o        = do_q;
  assign do_oe_o     = oe_q;
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [1:0] rst_sq;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ns = rst_sq[1];

  logic [2:0] pins_s;
  logic cs_s, sk_s, di_s, sk_prev_q, sk_rise;
  uwe_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_ns), .a_i({cs_i, sk_i, di_i}), .s_o(pins_s)
  );
  assign {cs_s, sk_s, di_s} = pins_s;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) sk_prev_q <= 1'b0;
    else         sk_prev_q <= sk_s;
  end
  assign sk_rise = sk_s && !sk_prev_q;

  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [DATA_W-1:0] rd_data, prog_data;
  logic prog_start, prog_all, busy, wen, start_acc;

  uwe_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .cs_i(cs_s), .sk_rise_i(sk_rise), .di_i(di_s),
    .busy_i(busy), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .prog_start_o(prog_start), .prog_all_o(prog_all), .prog_addr_o(prog_addr),
    .prog_data_o(prog_data), .wen_o(wen), .start_acc_o(start_acc),
    .do_o(do_o), .do_oe_o(do_oe_o)
  );

  uwe_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_ns), .start_i(prog_start), .busy_o(busy)
  );

  uwe_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_ns), .we_i(prog_start), .all_i(prog_all),
    .waddr_i(prog_addr), .wdata_i(prog_data), .raddr_i(rd_addr), .rdata_o(rd_data)
  );
endmodule

// File: rtl/uwe_checker.sv
module uwe_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sk_rise,
  input logic di_s,
  input logic start_acc,
  input logic busy,
  input logic prog_start,
  input logic wen,
  input logic do_oe
);
  AST_DO_HIZ_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !do_oe); // R9
  AST_NO_PROG_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen); // R5
  AST_PROG_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !cs_s); // R6
  AST_BUSY_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy); // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> !busy); // R8
  AST_START_ON_DI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> (sk_rise && di_s && cs_s)); // R1
endmodule

bind uwire_eeprom uwe_checker u_chk (
  .clk(clk), .rst_n(rst_ns), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
  .start_acc(start_acc), .busy(busy), .prog_start(prog_start), .wen(wen),
  .do_oe(do_oe_o)
);

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
  localparam int PROG = 800;

  logic clk, rst_n, cs, sk, di;
  logic do_o, do_oe;
  int n_chk, n_bad;
  logic [15:0] ref_mem [128];
  bit done;

  uwire_eeprom #(.ADDR_W(7), .DATA_W(16), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_o), .do_oe_o(do_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic q, output logic oe);
    di = b;
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (8) @(negedge clk);
    q = do_o; oe = do_oe;
    sk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_up();
    cs = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic cs_down();
    cs = 1'b0; di = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] fld, input int zeros,
                     output logic q, output logic oe);
    for (int i = 0; i < zeros; i++) bit_io(1'b0, q, oe);
    bit_io(1'b1, q, oe);
    for (int i = 1; i >= 0; i--) bit_io(op[i], q, oe);
    for (int i = 7; i >= 0; i--) bit_io(fld[i], q, oe);
  endtask

  task automatic rd_words(input logic [6:0] a, input int nw, input string req);
    logic q, oe;
    logic [15:0] w;
    for (int k = 0; k < nw; k++) begin
      for (int b = 15; b >= 0; b--) begin
        bit_io(1'b0, q, oe);
        w[b] = q;
      end
      check(req, {16'h0, w}, {16'h0, ref_mem[7'(a + 7'(k))]});
    end
  endtask

  task automatic rd(input logic [6:0] a, input int nw, input int zeros, input string req);
    logic q, oe;
    cs_up();
    hdr(2'b10, {1'b0, a}, zeros, q, oe);
    check({req, " dummy bit R3"}, {30'h0, oe, q}, 32'h2);
    rd_words(a, nw, req);
    cs_down();
    check({req, " DO off after CS low R9"}, {31'h0, do_oe}, 32'h0);
  endtask

  // store command; expect_prog tells whether busy must be shown afterwards
  task automatic store(input logic [1:0] op, input logic [7:0] fld, input logic [15:0] d,
                       input bit has_data, input bit expect_prog, input string req);
    logic q, oe;
    cs_up();
    hdr(op, fld, 0, q, oe);
    if (has_data) for (int i = 15; i >= 0; i--) bit_io(d[i], q, oe);
    cs_down();
    cs_up();
    bit_io(1'b0, q, oe);
    if (expect_prog) begin
      check({req, " busy shown R8"}, {30'h0, oe, q}, 32'h2);
      repeat (PROG + 20) @(negedge clk);
      bit_io(1'b0, q, oe);
      check({req, " ready shown R8"}, {30'h0, oe, q}, 32'h3);
    end else begin
      check({req, " no programming cycle"}, {31'h0, oe}, 32'h0);
    end
    cs_down();
  endtask

  task automatic special(input logic [1:0] code);
    logic q, oe;
    cs_up();
    hdr(2'b00, {code, 6'b101010}, 0, q, oe);
    cs_down();
  endtask

  initial begin
    done = 1'b0;
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic q, oe;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    for (int i = 0; i < 128; i++) ref_mem[i] = 16'hFFFF;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R10 DO disabled after reset", {31'h0, do_oe}, 32'h0);
    rd(7'd5, 1, 0, "R10 erased after reset");

    store(2'b01, 8'h03, 16'h1234, 1'b1, 1'b0, "R5 write while protected");
    rd(7'd3, 1, 0, "R5 protected word unchanged");

    special(2'b11);
    store(2'b01, 8'h03, 16'h1234, 1'b1, 1'b1, "R6 write");
    ref_mem[3] = 16'h1234;
    rd(7'd3, 1, 3, "R1 leading zeros before start, R6 data");

    // cancel: CS falls during the data bits
    cs_up();
    hdr(2'b01, 8'h04, 0, q, oe);
    for (int i = 0; i < 10; i++) bit_io(1'b0, q, oe);
    cs_down();
    cs_up();
    bit_io(1'b0, q, oe);
    check("R6 cancelled write starts nothing", {31'h0, oe}, 32'h0);
    cs_down();
    rd(7'd4, 1, 0, "R6 cancelled word unchanged");

    store(2'b01, 8'h7F, 16'hA5A5, 1'b1, 1'b1, "R4 setup top");
    ref_mem[127] = 16'hA5A5;
    store(2'b01, 8'h00, 16'h0F0F, 1'b1, 1'b1, "R4 setup bottom");
    ref_mem[0] = 16'h0F0F;
    rd(7'd126, 3, 0, "R4 auto increment with wrap");

    // busy refusal, then ready and a new start bit with CS still high
    cs_up();
    hdr(2'b01, 8'h0A, 0, q, oe);
    for (int i = 15; i >= 0; i--) bit_io(1'b0, q, oe);
    cs_down();
    ref_mem[10] = 16'h0000;
    cs_up();
    hdr(2'b10, 8'h0B, 0, q, oe);
    check("R8 read refused while busy, status", {30'h0, oe, q}, 32'h2);
    bit_io(1'b0, q, oe);
    check("R8 no data while busy", {30'h0, oe, q}, 32'h2);
    repeat (PROG) @(negedge clk);
    bit_io(1'b0, q, oe);
    check("R8 ready after programming", {30'h0, oe, q}, 32'h3);
    hdr(2'b10, 8'h03, 0, q, oe);
    check("R11 start after ready, dummy", {30'h0, oe, q}, 32'h2);
    rd_words(7'd3, 1, "R11 read after ready");
    cs_down();
    rd(7'd10, 1, 0, "R6 word written before busy test");

    // abandoned read, then a clean read
    cs_up();
    hdr(2'b10, 8'h03, 0, q, oe);
    bit_io(1'b0, q, oe); bit_io(1'b0, q, oe);
    cs_down();
    check("R9 DO off after abandoned read", {31'h0, do_oe}, 32'h0);
    rd(7'd0, 1, 0, "R9 read after abandon");

    store(2'b11, 8'h03, 16'h0, 1'b0, 1'b1, "R7 erase");
    ref_mem[3] = 16'hFFFF;
    rd(7'd3, 1, 0, "R7 erased word");

    store(2'b00, 8'b0100_0000, 16'h5A5A, 1'b1, 1'b1, "R7 fill all");
    for (int i = 0; i < 128; i++) ref_mem[i] = 16'h5A5A;
    rd(7'd77, 1, 0, "R7 fill all mid");
    rd(7'd127, 2, 0, "R7 fill all ends");

    store(2'b00, 8'b1000_0000, 16'h0, 1'b0, 1'b1, "R7 clear all");
    for (int i = 0; i < 128; i++) ref_mem[i] = 16'hFFFF;
    rd(7'd64, 1, 0, "R7 clear all");

    store(2'b01, 8'h20, 16'h1111, 1'b1, 1'b1, "R2 write");
    ref_mem[32] = 16'h1111;
    special(2'b00);
    store(2'b01, 8'h20, 16'h2222, 1'b1, 1'b0, "R5 write after disable");
    store(2'b00, 8'b1000_0000, 16'h0, 1'b0, 1'b0, "R5 clear all after disable");
    rd(7'd32, 1, 0, "R5 read while disabled");

    special(2'b11);
    for (int n = 0; n < 24; n++) begin
      int kind;
      logic [6:0] a;
      logic [15:0] d;
      kind = int'($urandom_range(0, 3));
      a = 7'($urandom_range(0, 127));
      d = 16'($urandom);
      case (kind)
        0, 1: rd(a, int'($urandom_range(1, 2)), int'($urandom_range(0, 2)), "R2 random read");
        2: begin
          store(2'b01, {1'b0, a}, d, 1'b1, 1'b1, "R2 random write");
          ref_mem[a] = d;
          rd(a, 1, 0, "R2 random write readback");
        end
        default: begin
          store(2'b11, {1'b0, a}, 16'h0, 1'b0, 1'b1, "R2 random erase");
          ref_mem[a] = 16'hFFFF;
          rd(a, 1, 0, "R2 random erase readback");
        end
      endcase
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule